// File: doc/BRIEF.md
# Selectable Sinc Decimation Filter

This block turns a one-bit delta-sigma bitstream into signed, decimated words. Each accepted input bit counts as +1 (bit high) or -1 (bit low). The bits pass through a chain of wrap-around integrators that runs at the input rate. At every decimation point a chain of comb differences takes the integrator result. One word comes out for every OSR accepted bits, so the response has its first notch at the output word rate.

A two-bit select picks one of three responses:
- a third-order sinc, for accurate measurement;
- a second-order sinc, for quick detection;
- a "fast" response: the second-order result plus the second-order result from two words earlier, which adds a delay of 2·OSR input samples.

OSR is a power of two, chosen at run time through its base-two logarithm. The output is shifted left by the order times the distance to the largest OSR. A given bit density therefore gives the same word at every OSR.

Both data edges use a valid/ready handshake. A finished word stays on `m_data` with `m_valid` high until the consumer takes it. While a word is held and not taken, `s_ready` stays low, so no input bit is lost and none is counted twice. The configuration inputs are plain levels. Any change to them restarts the filter.

Top module: `sincdec_filter`

## Requirements
- R1: One output word is produced per 2^L accepted input bits, where L is `osr_log2` clamped to the range LOG2_MIN..LOG2_MAX (defaults 4 and 8); values below or above that range act as the nearest limit.
- R2: With `filt_sel` = 0 (third order), a settled word equals the mean of the ±1 input over a period dividing OSR, times 2^(3·LOG2_MAX); all ones gives 2^24 at the defaults.
- R3: With `filt_sel` = 1 (second order), a settled word equals the ±1 mean times 2^(2·LOG2_MAX); all zeros gives -2^16 at the defaults.
- R4: With `filt_sel` = 2 (fast), each word is the second-order result plus the second-order result produced two words earlier. A settled word is therefore twice the second-order value; the pattern 1,1,1,0 gives 2^16.
- R5: `filt_sel` = 3 behaves exactly as the third-order response.
- R6: `settled` is low after reset and after a restart. It rises together with `m_valid` of the 3rd word (third order), the 2nd word (second order) or the 4th word (fast), and then stays high until the next restart.
- R7: In any cycle where `osr_log2` or `filt_sel` differs from its value in the previous cycle, `s_ready` is low. The integrators, combs, delay history, decimation count and word count are cleared, and `settled` is low from the next cycle.
- R8: While `m_valid` is high and `m_ready` is low, `m_data` and `m_valid` hold, `s_ready` is low, and an offered bit is not consumed.
- R9: The integrators wrap modulo 2^(3·LOG2_MAX+2). Words stay exact over long runs at the largest OSR.
- R10: During reset `m_valid`, `settled` and `m_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osr_log2 | input | L_W (4) | Base-two log of OSR, clamped |
| filt_sel | input | 2 | 0 third order, 1 second order, 2 fast, 3 as 0 |
| s_valid | input | 1 | Input bit offered |
| s_bit | input | 1 | Bitstream sample |
| s_ready | output | 1 | Input bit accepted when high with s_valid |
| m_valid | output | 1 | Output word available |
| m_data | output | ACC_W (26) | Signed scaled output word |
| m_ready | input | 1 | Consumer takes the word |
| settled | output | 1 | Current and later words are fully settled |

## Verification
Two pairs of events can land in the same cycle. The first is a configuration change while a bit is offered. The bench flips `filt_sel` in the middle of a decimation period and offers a bit in that same cycle. It expects that bit to be refused. It then expects exactly two words, the second marked settled, after 32 more accepted bits. The second pair is a held output word and a new bit arriving. The bench keeps `m_ready` low for several cycles while offering bits and expects `m_data` to stay unchanged. It then counts the bits needed for the next word, which shows that no stalled bit was absorbed.

// File: rtl/sincdec_pkg.sv
package sincdec_pkg;

  typedef enum logic [1:0] {
    FILT_SINC3 = 2'd0,
    FILT_SINC2 = 2'd1,
    FILT_FAST  = 2'd2,
    FILT_ALT3  = 2'd3
  } filt_e;

  // number of integrator/comb stages in use
  function automatic logic [1:0] order_of(filt_e f);
    case (f)
      FILT_SINC2, FILT_FAST: order_of = 2'd2;
      default:               order_of = 2'd3;
    endcase
  endfunction

  // words needed after a restart before results are exact
  function automatic logic [2:0] settle_words(filt_e f);
    case (f)
      FILT_SINC2: settle_words = 3'd2;
      FILT_FAST:  settle_words = 3'd4;
      default:    settle_words = 3'd3;
    endcase
  endfunction

endpackage

// File: rtl/sincdec_integ.sv
module sincdec_integ #(
  parameter int W      = 26,
  parameter int STAGES = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        en,
  input  logic                        in_bit,
  output logic [STAGES-1:0][W-1:0]    acc_nxt
);
  localparam logic [W-1:0] STEP_UP = W'(1);
  localparam logic [W-1:0] STEP_DN = '1;

  logic [STAGES-1:0][W-1:0] acc_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign acc_nxt[s] = acc_q[s] + (in_bit ? STEP_UP : STEP_DN);
    end else begin : g_rest
      assign acc_nxt[s] = acc_q[s] + acc_nxt[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (clr)   acc_q <= '0;
    else if (en)    acc_q <= acc_nxt;
  end
endmodule

// File: rtl/sincdec_comb.sv
module sincdec_comb #(
  parameter int W      = 26,
  parameter int STAGES = 3,
  localparam int N_W   = $clog2(STAGES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           en,
  input  logic [N_W-1:0] n_act,
  input  logic [W-1:0]   in_val,
  output logic [W-1:0]   y
);
  logic [STAGES:0][W-1:0]   stage_in;
  logic [STAGES-1:0][W-1:0] prev_q;

  assign stage_in[0] = in_val;
  for (genvar s = 0; s < STAGES; s++) begin : g_diff
    assign stage_in[s+1] = stage_in[s] - prev_q[s];
  end

  always_comb begin
    y = stage_in[STAGES];
    for (int s = 0; s < STAGES; s++) begin
      if (n_act == N_W'(s + 1)) y = stage_in[s+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev_q <= '0;
    else if (clr) prev_q <= '0;
    else if (en)  prev_q <= stage_in[STAGES-1:0];
  end
endmodule

// File: rtl/sincdec_fastadd.sv
module sincdec_fastadd #(
  parameter int W     = 26,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] in_val,
  output logic [W-1:0] sum
);
  logic [DEPTH-1:0][W-1:0] hist_q;

  assign sum = in_val + hist_q[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hist_q <= '0;
    else if (clr) hist_q <= '0;
    else if (en) begin
      hist_q[0] <= in_val;
      for (int d = 1; d < DEPTH; d++) hist_q[d] <= hist_q[d-1];
    end
  end
endmodule

// File: rtl/sincdec_filter.sv
module sincdec_filter
  import sincdec_pkg::*;
#(
  parameter int LOG2_MIN = 4,
  parameter int LOG2_MAX = 8,
  localparam int L_W     = $clog2(LOG2_MAX + 1),
  localparam int ACC_W   = 3 * LOG2_MAX + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [L_W-1:0]   osr_log2,
  input  logic [1:0]       filt_sel,
  input  logic             s_valid,
  input  logic             s_bit,
  output logic             s_ready,
  output logic             m_valid,
  output logic [ACC_W-1:0] m_data,
  input  logic             m_ready,
  output logic             settled
);
  localparam int ORDER_MAX = 3;
  localparam int CNT_W     = LOG2_MAX;
  localparam int SH_W      = $clog2(ORDER_MAX * LOG2_MAX + 1);
  localparam logic [L_W-1:0] L_MIN_V = L_W'(LOG2_MIN);
  localparam logic [L_W-1:0] L_MAX_V = L_W'(LOG2_MAX);

  logic [L_W-1:0]   l_eff, osr_q;
  logic [1:0]       sel_q;
  filt_e            mode;
  logic [1:0]       ord;
  logic [2:0]       need;
  logic             restart, accept, dec_evt;
  logic [CNT_W-1:0] cnt, osr_m1;
  logic [ORDER_MAX-1:0][ACC_W-1:0] acc_nxt;
  logic [ACC_W-1:0] comb_in, comb_y, fast_sum, raw, scaled;
  logic [SH_W-1:0]  sh;
  logic [2:0]       wcnt;

  // configuration decode
  always_comb begin
    if (osr_log2 < L_MIN_V)      l_eff = L_MIN_V;
    else if (osr_log2 > L_MAX_V) l_eff = L_MAX_V;
    else                         l_eff = osr_log2;
  end

  assign mode   = filt_e'(filt_sel);
  assign ord    = order_of(mode);
  assign need   = settle_words(mode);
  assign osr_m1 = {CNT_W{1'b1}} >> (L_MAX_V - l_eff);

  assign restart = (osr_log2 != osr_q) || (filt_sel != sel_q);
  assign s_ready = !restart && !(m_valid && !m_ready);
  assign accept  = s_valid && s_ready;
  assign dec_evt = accept && (cnt == osr_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osr_q <= L_MAX_V;
      sel_q <= 2'd0;
    end else begin
      osr_q <= osr_log2;
      sel_q <= filt_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (accept)  cnt <= dec_evt ? '0 : cnt + CNT_W'(1);
  end

  // datapath
  sincdec_integ #(.W(ACC_W), .STAGES(ORDER_MAX)) integ_i (
    .clk(clk), .rst_n(rst_n), .clr(restart), .en(accept),
    .in_bit(s_bit), .acc_nxt(acc_nxt)
  );

  assign comb_in = (ord == 2'd3) ? acc_nxt[2] : acc_nxt[1];

  sincdec_comb #(.W(ACC_W), .STAGES(ORDER_MAX)) comb_i (
    .clk(clk), .rst_n(rst_n), .clr(restart), .en(dec_evt),
    .n_act(ord), .in_val(comb_in), .y(comb_y)
  );

  sincdec_fastadd #(.W(ACC_W), .DEPTH(2)) fast_i (
    .clk(clk), .rst_n(rst_n), .clr(restart), .en(dec_evt),
    .in_val(comb_y), .sum(fast_sum)
  );

  assign raw    = (mode == FILT_FAST) ? fast_sum : comb_y;
  assign sh     = SH_W'(ord) * SH_W'(L_MAX_V - l_eff);
  assign scaled = raw << sh;

  // output word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (dec_evt) begin
      m_valid <= 1'b1;
      m_data  <= scaled;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // settling tracker
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt    <= '0;
      settled <= 1'b0;
    end else if (restart) begin
      wcnt    <= '0;
      settled <= 1'b0;
    end else if (dec_evt) begin
      if (wcnt != 3'd7) wcnt <= wcnt + 3'd1;
      settled <= ({1'b0, wcnt} + 4'd1) >= {1'b0, need};
    end
  end
endmodule

// File: rtl/sincdec_filter_chk.sv
module sincdec_filter_chk #(
  parameter int L_W      = 4,
  parameter int ACC_W    = 26,
  parameter int LOG2_MAX = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [L_W-1:0]   osr_log2,
  input logic [1:0]       filt_sel,
  input logic             s_valid,
  input logic             s_ready,
  input logic             m_valid,
  input logic [ACC_W-1:0] m_data,
  input logic             m_ready,
  input logic             settled
);
  logic [L_W-1:0] p_osr;
  logic [1:0]     p_sel;
  logic           chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_osr <= L_W'(LOG2_MAX);
      p_sel <= 2'd0;
    end else begin
      p_osr <= osr_log2;
      p_sel <= filt_sel;
    end
  end

  assign chg = (osr_log2 != p_osr) || (filt_sel != p_sel);

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data)); // R8
  AST_RESTART_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> !s_ready); // R7
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !settled); // R7
  AST_SETTLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> settled || $past(chg)); // R6
  AST_SETTLE_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> m_valid); // R6
  AST_WORD_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(s_valid && s_ready)); // R1
endmodule

bind sincdec_filter sincdec_filter_chk #(.L_W(L_W), .ACC_W(ACC_W), .LOG2_MAX(LOG2_MAX)) chk_i (
  .clk(clk), .rst_n(rst_n), .osr_log2(osr_log2), .filt_sel(filt_sel),
  .s_valid(s_valid), .s_ready(s_ready), .m_valid(m_valid), .m_data(m_data),
  .m_ready(m_ready), .settled(settled)
);

// File: tb/sincdec_filter_tb_top.sv
module sincdec_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int WD_CYCLES  = 100000;
  localparam int L_W        = 4;
  localparam int ACC_W      = 26;

  localparam int PAT_ZERO = 0;
  localparam int PAT_ONE  = 1;
  localparam int PAT_ALT  = 2;
  localparam int PAT_3OF4 = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [L_W-1:0]   osr_log2 = 4'd8;
  logic [1:0]       filt_sel = 2'd0;
  logic             s_valid = 1'b0;
  logic             s_bit = 1'b0;
  logic             s_ready;
  logic             m_valid;
  logic [ACC_W-1:0] m_data;
  logic             m_ready = 1'b1;
  logic             settled;

  int n_cmp = 0;
  int n_bad = 0;
  longint got_w[$];
  bit     got_s[$];

  always #(HALF) clk = ~clk;

  sincdec_filter dut_i (
    .clk(clk), .rst_n(rst_n), .osr_log2(osr_log2), .filt_sel(filt_sel),
    .s_valid(s_valid), .s_bit(s_bit), .s_ready(s_ready),
    .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready), .settled(settled)
  );

  // capture each handshaken word just before the edge that completes it
  initial begin
    forever begin
      @(negedge clk);
      #(HALF - 1);
      if (rst_n && m_valid && m_ready) begin
        got_w.push_back(longint'($signed(m_data)));
        got_s.push_back(settled);
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [L_W-1:0] l, input logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0;
    osr_log2 = l;
    filt_sel = sel;
    s_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    got_w.delete();
    got_s.delete();
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic push(input logic b);
    s_valid = 1'b1;
    s_bit = b;
    #1;
    while (!s_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  function automatic logic pat_bit(input int pat, input int i);
    case (pat)
      PAT_ZERO: return 1'b0;
      PAT_ONE:  return 1'b1;
      PAT_ALT:  return (i % 2) == 0;
      default:  return (i % 4) != 3;
    endcase
  endfunction

  task automatic run_bits(input int n, input int pat);
    for (int i = 0; i < n; i++) push(pat_bit(pat, i));
    @(negedge clk);
  endtask

  task automatic check_words(input string req, input int from, input int upto, input longint exp);
    for (int k = from; k <= upto; k++) begin
      if (k < got_w.size()) check(req, $sformatf("word %0d", k + 1), got_w[k], exp);
      else check(req, $sformatf("word %0d missing", k + 1), 0, 1);
    end
  endtask

  task automatic check_flags(input string req, input int upto, input int first_set);
    for (int k = 0; k <= upto; k++) begin
      if (k < got_s.size())
        check(req, $sformatf("settled at word %0d", k + 1), longint'(got_s[k]), (k >= first_set) ? 1 : 0);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10", "m_valid in reset", longint'(m_valid), 0);
    check("R10", "settled in reset", longint'(settled), 0);
    check("R10", "m_data in reset", longint'(m_data), 0);
  endtask

  task automatic t_sinc3_ones();
    do_reset(4'd4, 2'd0);
    run_bits(64, PAT_ONE);
    check("R1", "word count osr16", got_w.size(), 4);
    check_words("R2", 2, 3, 64'sd1 <<< 24);
    check_flags("R6", 3, 2);
  endtask

  task automatic t_sinc2_zeros();
    do_reset(4'd5, 2'd1);
    run_bits(96, PAT_ZERO);
    check("R1", "word count osr32", got_w.size(), 3);
    check_words("R3", 1, 2, -(64'sd1 <<< 16));
    check_flags("R6", 2, 1);
  endtask

  task automatic t_fast_pattern();
    do_reset(4'd4, 2'd2);
    run_bits(80, PAT_3OF4);
    check_words("R4", 3, 4, 64'sd1 <<< 16);
    check_flags("R6", 4, 3);
  endtask

  task automatic t_sel3_alias();
    do_reset(4'd4, 2'd3);
    run_bits(48, PAT_ALT);
    check_words("R5", 2, 2, 0);
    check_flags("R5", 2, 2);
  endtask

  task automatic t_long_wrap();
    do_reset(4'd8, 2'd0);
    run_bits(256 * 6, PAT_ONE);
    check("R9", "word count osr256", got_w.size(), 6);
    check_words("R9", 2, 5, 64'sd1 <<< 24);
  endtask

  task automatic t_clamp();
    do_reset(4'd1, 2'd1);
    run_bits(32, PAT_ONE);
    check("R1", "word count clamped low", got_w.size(), 2);
    check_words("R1", 1, 1, 64'sd1 <<< 16);
  endtask

  task automatic t_restart();
    do_reset(4'd4, 2'd0);
    run_bits(48, PAT_ONE);
    check("R6", "settled before change", longint'(settled), 1);
    for (int i = 0; i < 8; i++) push(1'b1);
    filt_sel = 2'd1;
    s_valid = 1'b1;
    s_bit = 1'b0;
    #1;
    check("R7", "s_ready in change cycle", longint'(s_ready), 0);
    @(negedge clk);
    s_valid = 1'b0;
    check("R7", "settled after change", longint'(settled), 0);
    got_w.delete();
    got_s.delete();
    run_bits(32, PAT_ONE);
    check("R7", "words after restart", got_w.size(), 2);
    check_flags("R7", 1, 1);
    check_words("R7", 1, 1, 64'sd1 <<< 16);
  endtask

  task automatic t_backpressure();
    logic [ACC_W-1:0] held;
    m_ready = 1'b0;
    do_reset(4'd4, 2'd1);
    for (int i = 0; i < 16; i++) push(1'b1);
    #1;
    check("R8", "m_valid held", longint'(m_valid), 1);
    check("R8", "s_ready while held", longint'(s_ready), 0);
    held = m_data;
    s_valid = 1'b1;
    s_bit = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    check("R8", "m_data stable", longint'(m_data), longint'(held));
    check("R8", "m_valid still high", longint'(m_valid), 1);
    s_valid = 1'b0;
    m_ready = 1'b1;
    @(negedge clk);
    check("R8", "word taken once", got_w.size(), 1);
    for (int i = 0; i < 15; i++) push(1'b1);
    @(negedge clk);
    check("R8", "no stalled bit consumed", got_w.size(), 1);
    push(1'b1);
    @(negedge clk);
    check("R8", "next word after full period", got_w.size(), 2);
    check_words("R8", 1, 1, 64'sd1 <<< 16);
  endtask

  initial begin
    t_reset_state();
    t_sinc3_ones();
    t_sinc2_zeros();
    t_fast_pattern();
    t_sel3_alias();
    t_clamp();
    t_restart();
    t_backpressure();
    t_long_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule